// File: doc/BRIEF.md
# Bitwise Logic Unit with Bit Clear

This block is the logical half of an execute stage. It takes a first operand and a second operand, applies one of four bitwise functions chosen by a 2-bit opcode, and returns a 32-bit result in the same cycle. The second operand comes in already resolved, either from a shifter stage or from a decoded immediate. The block has no clock and no reset.

The four functions are AND, OR, exclusive OR, and bit clear. Bit clear keeps a bit of the first operand only where the matching bit of the second operand is 0, which makes it the usual way to mask off a field. Each result bit depends only on the operand bits in the same position.

Two indicators come with the result. One says the result is all zeros. The other copies the top bit of the result, so it reads as a sign.

Top module: `bitlogic_unit`

## Requirements
- R1: With opcode 2'b00 (AND), a result bit is 1 only when both operand bits at that position are 1. For example, 0x3B and 0x92 give 0x12.
- R2: With opcode 2'b01 (bit clear), a result bit is 1 only when the first-operand bit is 1 and the second-operand bit is 0. For example, 0x12345678 with 0x0000FFFF gives 0x12340000.
- R3: With opcode 2'b10 (OR), a result bit is 1 when either operand bit is 1. For example, 0x3B and 0x92 give 0xBB.
- R4: With opcode 2'b11 (exclusive OR), a result bit is 1 when the two operand bits differ. For example, 0x3B and 0x92 give 0xA9.
- R5: `zero_o` is 1 exactly when all 32 bits of `res_o` are 0.
- R6: `neg_o` equals bit 31 of `res_o`.
- R7: The outputs depend only on the present inputs. They change within the same cycle as the inputs, with no clock and no retained state.
- R8: The bit positions are independent. Flipping one operand bit changes at most the result bit at that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted or expanded from an immediate |
| op_i | input | 2 | Function select: 00 AND, 01 bit clear, 10 OR, 11 exclusive OR |
| res_o | output | 32 | Bitwise result |
| zero_o | output | 1 | High when the result is all zeros |
| neg_o | output | 1 | Copy of result bit 31 |

## Verification
The hardest property to reach from the ports is R8, bit independence. Random operands alone would not reveal a bit that leaks into a neighbouring position. The stimulus therefore takes a base operand pair and replays it with exactly one bit flipped, once for every bit position of both operands and for every opcode. It then confirms that at most that one result bit moves. The flag corners are reached on purpose rather than by chance:
- operands whose result is exactly zero;
- operands whose result is zero except for bit 31;
- operands whose result is zero except for bit 0.

// File: rtl/bitlogic_pkg.sv
// Package: shared types for the bitwise logic unit.
// Assumes: the opcode is two bits wide and its encoding is fixed.
package bitlogic_pkg;

    typedef enum logic [1:0] {
        BL_AND   = 2'b00,
        BL_CLEAR = 2'b01,
        BL_OR    = 2'b10,
        BL_XOR   = 2'b11
    } bl_op_e;

endpackage

// File: rtl/bitlogic_lane.sv
// Module: bitlogic_lane
// Computes the selected bitwise function over one slice of the operands.
// It also reports whether its own slice of the result is all zeros.
// Assumes: the opcode is stable for the whole slice; purely combinational.
module bitlogic_lane
    import bitlogic_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  bl_op_e            op_i,
    output logic [LANE_W-1:0] y_o,
    output logic              lane_zero_o
);

    // Purpose: apply the chosen function to every bit of the slice.
    always_comb begin
        unique case (op_i)
            BL_AND:   y_o = a_i & b_i;
            BL_CLEAR: y_o = a_i & ~b_i;
            BL_OR:    y_o = a_i | b_i;
            default:  y_o = a_i ^ b_i;
        endcase
    end

    // Purpose: local all-zero detect for this slice.
    always_comb begin
        lane_zero_o = ~|y_o;
    end

endmodule

// File: rtl/bitlogic_flags.sv
// Module: bitlogic_flags
// Combines the per-slice zero detects into the result-zero indicator.
// Takes the sign indicator from the most significant result bit.
// Assumes: NUM_LANES slices together cover the whole result.
module bitlogic_flags #(
    parameter int WIDTH     = 32,
    parameter int NUM_LANES = 4
) (
    input  logic [WIDTH-1:0]     res_i,
    input  logic [NUM_LANES-1:0] lane_zero_i,
    output logic                 zero_o,
    output logic                 neg_o
);

    // Purpose: the result is zero only when every slice is zero.
    always_comb begin
        zero_o = &lane_zero_i;
    end

    // Purpose: the sign indicator follows the top result bit.
    always_comb begin
        neg_o = res_i[WIDTH-1];
    end

endmodule

// File: rtl/bitlogic_unit.sv
// Module: bitlogic_unit (top)
// Bitwise logic unit: AND, bit clear, OR and exclusive OR, plus zero and sign indicators.
// It splits the datapath into LANE_W-bit slices with a generate loop.
// Assumes: WIDTH is a multiple of LANE_W. No clock or reset; fully combinational.
module bitlogic_unit
    import bitlogic_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int LANE_W = 8
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             neg_o
);

    localparam int NUM_LANES = WIDTH / LANE_W;

    bl_op_e                op_sel;
    logic [NUM_LANES-1:0]  lane_zero;

    // Purpose: map the raw opcode onto the shared enum.
    always_comb begin
        op_sel = bl_op_e'(op_i);
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bitlogic_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .a_i         (opa_i[g*LANE_W +: LANE_W]),
            .b_i         (opb_i[g*LANE_W +: LANE_W]),
            .op_i        (op_sel),
            .y_o         (res_o[g*LANE_W +: LANE_W]),
            .lane_zero_o (lane_zero[g])
        );
    end

    bitlogic_flags #(
        .WIDTH     (WIDTH),
        .NUM_LANES (NUM_LANES)
    ) u_flags (
        .res_i       (res_o),
        .lane_zero_i (lane_zero),
        .zero_o      (zero_o),
        .neg_o       (neg_o)
    );

    // Purpose: check each function's bit relations at the ports.
    always_comb begin
        if (!$isunknown({opa_i, opb_i, op_i})) begin
            // R1
            and_subset_chk: assert (op_i != 2'b00 ||
                ((res_o & ~opa_i) == '0 && (res_o & ~opb_i) == '0 &&
                 ((opa_i & opb_i) & ~res_o) == '0));
            // R2
            clear_masked_chk: assert (op_i != 2'b01 ||
                ((res_o & opb_i) == '0 && (res_o & ~opa_i) == '0 &&
                 (res_o | opb_i) == (opa_i | opb_i)));
            // R3
            or_cover_chk: assert (op_i != 2'b10 ||
                ((opa_i & ~res_o) == '0 && (opb_i & ~res_o) == '0 &&
                 (res_o & ~opa_i & ~opb_i) == '0));
            // R4
            xor_invert_chk: assert (op_i != 2'b11 || ((res_o ^ opb_i) == opa_i));
            // R5
            zero_flag_chk: assert (zero_o == (res_o == '0));
            // R6
            flag_excl_chk: assert (!(zero_o && neg_o));
        end
    end

endmodule

// File: tb/bitlogic_unit_bench.sv
// Bench for bitlogic_unit. A behavioural model computes each result one bit at a time
// from truth tables; the bench compares it with the design on every clock.
module bitlogic_unit_bench;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic [W-1:0]  opa, opb;
    logic [1:0]    op;
    logic [W-1:0]  res;
    logic          zero, neg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bitlogic_unit u_bitlogic_unit (
        .opa_i  (opa),
        .opb_i  (opb),
        .op_i   (op),
        .res_o  (res),
        .zero_o (zero),
        .neg_o  (neg)
    );

    // Behavioural reference: truth table per bit.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] o);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx;
            idx = {a[i], b[i]};
            case (o)
                2'b00: r[i] = (idx == 3);
                2'b01: r[i] = (idx == 2);
                2'b10: r[i] = (idx != 0);
                default: r[i] = (idx == 1) || (idx == 2);
            endcase
        end
        return r;
    endfunction

    function automatic string optag(input logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a vector at a rising edge, then sample at the next falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] o);
        logic [W-1:0] e;
        @(posedge clk);
        opa = a; opb = b; op = o;
        @(negedge clk);
        e = model(a, b, o);
        check(optag(o), res, e);
        check("R5", {31'd0, zero}, {31'd0, (e == '0)});
        check("R6", {31'd0, neg}, {31'd0, e[W-1]});
    endtask

    initial begin
        opa = '0; opb = '0; op = 2'b00;
        @(negedge clk);
        // Start-up state with zero operands: R7, R5
        check("R7", res, '0);
        check("R5", {31'd0, zero}, 32'd1);
        // Worked examples
        apply(32'h3B, 32'h92, 2'b00); check("R1", res, 32'h12);
        apply(32'h3B, 32'h92, 2'b10); check("R3", res, 32'hBB);
        apply(32'h3B, 32'h92, 2'b11); check("R4", res, 32'hA9);
        apply(32'h12345678, 32'h0000FFFF, 2'b01); check("R2", res, 32'h12340000);
        // Flag corners: only bit 31, only bit 0, exactly zero
        apply(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'b01); check("R6", {31'd0, neg}, 32'd1);
        apply(32'h0000_0001, 32'h0000_0001, 2'b00); check("R5", {31'd0, zero}, 32'd0);
        apply(32'hA5A5_A5A5, 32'hA5A5_A5A5, 2'b11); check("R5", {31'd0, zero}, 32'd1);
        // Patterns across all opcodes
        for (int o = 0; o < 4; o++) begin
            apply(32'hFFFF_FFFF, 32'h0000_0000, o[1:0]);
            apply(32'hAAAA_AAAA, 32'h5555_5555, o[1:0]);
            apply(32'hF0F0_0F0F, 32'hFF00_FF00, o[1:0]);
        end
        // Same-cycle response to an opcode change with fixed operands: R7
        @(posedge clk); opa = 32'hC3C3_C3C3; opb = 32'h0FF0_0FF0; op = 2'b10;
        #1 check("R7", res, 32'hCFF3_CFF3);
        op = 2'b01;
        #1 check("R7", res, 32'hC003_C003);
        // Random vectors
        for (int k = 0; k < 400; k++)
            apply($urandom, $urandom, 2'($urandom));
        // Single-bit flips: R8
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < W; i++) begin
                logic [W-1:0] base_r, flip_r;
                apply(32'h6C39_B1E4, 32'h93D2_4A17, o[1:0]);
                base_r = res;
                apply(32'h6C39_B1E4 ^ (32'd1 << i), 32'h93D2_4A17, o[1:0]);
                flip_r = res;
                check("R8", (base_r ^ flip_r) & ~(32'd1 << i), '0);
                apply(32'h6C39_B1E4, 32'h93D2_4A17 ^ (32'd1 << i), o[1:0]);
                flip_r = res;
                check("R8", (base_r ^ flip_r) & ~(32'd1 << i), '0);
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule